// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block keeps two 64-bit timer compare values, one for the supervisor level and one for the virtual-supervisor (VS) level, and turns them into two timer pending flags. The supervisor flag is raised while the free-running `time_i` count is at or past the supervisor compare value. The VS flag uses a shifted time base: `time_i + delta_i`, wrapped to 64 bits, is compared against the VS compare value. Both comparisons are unsigned. The VS flag drives the VS timer input of the hypervisor pending logic.

Software reaches the compare values through a small CSR decode. When `xlen64_i` is 1, one address per register carries the whole 64-bit value. When `xlen64_i` is 0, the same address carries the lower 32 bits and a second address carries the upper 32 bits. A pending flag stays high until software writes a compare value above the current time. Both flags are registered and follow their inputs one clock later.

Top module: `stc_timer_cmp`

## Requirements
- R1: While reset is held both pending outputs are 0. Reset sets the supervisor compare value to 0 and the VS compare value to all ones, so with `time_i` = 0 the supervisor flag reads 1 and the VS flag reads 0 one clock after release.
- R2: `s_pend_o` is 1 exactly when `time_i` >= supervisor compare value. It reflects the inputs sampled at the previous rising clock edge.
- R3: `vs_pend_o` is 1 exactly when (`time_i` + `delta_i`) mod 2^64 >= VS compare value. It also has one clock of latency.
- R4: With `xlen64_i` = 1, a write to address 0x14D loads all 64 bits of the supervisor compare value and a write to 0x24D loads all 64 bits of the VS compare value. Reads of those addresses return the full value.
- R5: With `xlen64_i` = 0, addresses 0x14D and 0x24D reach bits 31:0 and addresses 0x15D and 0x25D reach bits 63:32, each taking `csr_wdata_i[31:0]`. A write to one half leaves the other half unchanged. A read returns the selected half in bits 31:0 with bits 63:32 zero.
- R6: With `xlen64_i` = 1, addresses 0x15D and 0x25D read as 0 and writes to them change nothing.
- R7: Any other address reads as 0, and writes to it leave both compare values unchanged.
- R8: Writing a compare value above the current time clears the matching pending flag one clock after the write.
- R9: The comparisons are unsigned: a time with bit 63 set counts as greater than a compare value with bit 63 clear.
- R10: The VS sum wraps. A carry out of bit 63 is dropped, so a wrapped small sum below the VS compare value gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlen64_i | input | 1 | 1: 64-bit CSR access, 0: split 32-bit access |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | CSR read data, combinational from the address |
| time_i | input | 64 | Free-running time count |
| delta_i | input | 64 | Time offset for the VS time base |
| s_pend_o | output | 1 | Supervisor timer pending |
| vs_pend_o | output | 1 | VS timer pending |

## Verification
A corrupted compare register appears on both read-back and pending behaviour. A read of the address returns the wrong half or a changed half in the same cycle. A pending flag changes state at the wrong time one clock after the time input crosses the damaged value. The bench therefore pairs every write with read-backs of both halves. It also places time just above and just below each compare value, including a wrapped VS sum and a bit-63 split, so that a one-bit mistake in the adder or the comparator changes a flag within one cycle.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int TIME_W = 64;
    localparam int ADDR_W = 12;

    // Address pairs: the low address serves the full value in 64-bit mode.
    localparam logic [ADDR_W-1:0] ADDR_S_LO  = 12'h14D;
    localparam logic [ADDR_W-1:0] ADDR_S_HI  = 12'h15D;
    localparam logic [ADDR_W-1:0] ADDR_VS_LO = 12'h24D;
    localparam logic [ADDR_W-1:0] ADDR_VS_HI = 12'h25D;

    typedef struct packed {
        logic s;
        logic vs;
    } pend_t;
endpackage

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg #(
    parameter int              TW        = 64,
    parameter int              AW        = 12,
    parameter logic [AW-1:0]   ADDR_LO   = '0,
    parameter logic [AW-1:0]   ADDR_HI   = '0,
    parameter logic [TW-1:0]   RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] wdata_i,
    output logic [TW-1:0] cmp_o,
    output logic [TW-1:0] rdata_o
);
    localparam int HW = TW / 2;

    typedef struct packed {
        logic [TW-1:0] cmp;
    } state_t;

    state_t st_d, st_q;
    logic   hit_lo, hit_hi;

    always_comb begin
        st_d   = st_q;
        hit_lo = (addr_i == ADDR_LO);
        hit_hi = !wide_i && (addr_i == ADDR_HI);
        if (we_i && hit_lo) begin
            if (wide_i) st_d.cmp = wdata_i;
            else        st_d.cmp[HW-1:0] = wdata_i[HW-1:0];
        end
        if (we_i && hit_hi) begin
            st_d.cmp[TW-1:HW] = wdata_i[HW-1:0];
        end
        if (hit_lo)      rdata_o = wide_i ? st_q.cmp : {{HW{1'b0}}, st_q.cmp[HW-1:0]};
        else if (hit_hi) rdata_o = {{HW{1'b0}}, st_q.cmp[TW-1:HW]};
        else             rdata_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.cmp <= RESET_VAL;
        else        st_q     <= st_d;
    end

    assign cmp_o = st_q.cmp;

    // R5: a low-half write in split mode keeps the upper half
    a_r5_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wide_i && addr_i == ADDR_LO) |=> cmp_o[TW-1:HW] == $past(cmp_o[TW-1:HW]));

    // R5: an upper-half write in split mode keeps the lower half
    a_r5_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wide_i && addr_i == ADDR_HI) |=> cmp_o[HW-1:0] == $past(cmp_o[HW-1:0]));

    // R7: without a write strobe the compare value holds
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cmp_o));
endmodule

// File: rtl/stc_pend.sv
module stc_pend #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] delta_i,
    input  logic [TW-1:0] s_cmp_i,
    input  logic [TW-1:0] vs_cmp_i,
    output logic          s_pend_o,
    output logic          vs_pend_o
);
    import stc_pkg::*;

    pend_t         pend_d, pend_q;
    logic [TW-1:0] vs_time;

    always_comb begin
        vs_time   = time_i + delta_i;   // carry out of the top bit is dropped
        pend_d.s  = (time_i  >= s_cmp_i);
        pend_d.vs = (vs_time >= vs_cmp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign s_pend_o  = pend_q.s;
    assign vs_pend_o = pend_q.vs;
endmodule

// File: rtl/stc_timer_cmp.sv
module stc_timer_cmp
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlen64_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [TIME_W-1:0] csr_wdata_i,
    output logic [TIME_W-1:0] csr_rdata_o,
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] delta_i,
    output logic              s_pend_o,
    output logic              vs_pend_o
);
    logic [TIME_W-1:0] s_cmp, vs_cmp, s_rd, vs_rd;

    stc_cmp_reg #(
        .TW(TIME_W), .AW(ADDR_W), .ADDR_LO(ADDR_S_LO), .ADDR_HI(ADDR_S_HI),
        .RESET_VAL('0)
    ) s_reg_i (
        .clk(clk), .rst_n(rst_n), .wide_i(xlen64_i), .we_i(csr_we_i),
        .addr_i(csr_addr_i), .wdata_i(csr_wdata_i), .cmp_o(s_cmp), .rdata_o(s_rd)
    );

    stc_cmp_reg #(
        .TW(TIME_W), .AW(ADDR_W), .ADDR_LO(ADDR_VS_LO), .ADDR_HI(ADDR_VS_HI),
        .RESET_VAL('1)
    ) vs_reg_i (
        .clk(clk), .rst_n(rst_n), .wide_i(xlen64_i), .we_i(csr_we_i),
        .addr_i(csr_addr_i), .wdata_i(csr_wdata_i), .cmp_o(vs_cmp), .rdata_o(vs_rd)
    );

    stc_pend #(.TW(TIME_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .delta_i(delta_i),
        .s_cmp_i(s_cmp), .vs_cmp_i(vs_cmp), .s_pend_o(s_pend_o), .vs_pend_o(vs_pend_o)
    );

    // Addresses of the two registers never overlap, so an OR merges them.
    assign csr_rdata_o = s_rd | vs_rd;

    // R2: supervisor flag follows last cycle's unsigned comparison
    a_r2_s_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> s_pend_o == ($past(time_i) >= $past(s_cmp)));

    // R3: VS flag follows last cycle's wrapped sum comparison
    a_r3_vs_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> vs_pend_o == (TIME_W'($past(time_i) + $past(delta_i)) >= $past(vs_cmp)));

    // R6: upper-half addresses are silent in 64-bit mode
    a_r6_high_silent_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (xlen64_i && (csr_addr_i == ADDR_S_HI || csr_addr_i == ADDR_VS_HI)) |-> csr_rdata_o == '0);
endmodule

// File: tb/stc_timer_cmp_tb.sv
module stc_timer_cmp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlen64 = 1'b1;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [63:0] tm = '0;
    logic [63:0] dl = '0;
    logic        s_pend, vs_pend;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // bench-side model of the two compare values, updated from the requirements
    logic [63:0] m_s  = '0;
    logic [63:0] m_vs = '1;

    typedef struct {
        string       tag;
        bit          is_rd;
        logic [63:0] exp_rd;
        bit          exp_s;
        bit          exp_vs;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    stc_timer_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .xlen64_i(xlen64), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .time_i(tm), .delta_i(dl), .s_pend_o(s_pend), .vs_pend_o(vs_pend)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.is_rd) chk(it.tag, rdata, it.exp_rd);
            else begin
                chk({it.tag, " s_pend"},  {63'd0, s_pend},  {63'd0, it.exp_s});
                chk({it.tag, " vs_pend"}, {63'd0, vs_pend}, {63'd0, it.exp_vs});
            end
        end
    end

    task automatic push_item(item_t it);
        repeat (2) @(negedge clk);
        sb_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic exp_pend(string tag);
        item_t it;
        logic [63:0] sum;
        sum       = tm + dl;
        it.tag    = tag;
        it.is_rd  = 1'b0;
        it.exp_rd = '0;
        it.exp_s  = (tm >= m_s);
        it.exp_vs = (sum >= m_vs);
        push_item(it);
    endtask

    task automatic exp_rd(string tag, logic [11:0] a, logic [63:0] e);
        item_t it;
        addr      = a;
        it.tag    = tag;
        it.is_rd  = 1'b1;
        it.exp_rd = e;
        it.exp_s  = 1'b0;
        it.exp_vs = 1'b0;
        push_item(it);
    endtask

    task automatic csr_wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a == 12'h14D) begin
            if (xlen64) m_s = d; else m_s[31:0] = d[31:0];
        end else if (a == 12'h15D && !xlen64) m_s[63:32] = d[31:0];
        else if (a == 12'h24D) begin
            if (xlen64) m_vs = d; else m_vs[31:0] = d[31:0];
        end else if (a == 12'h25D && !xlen64) m_vs[63:32] = d[31:0];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 s_pend in reset",  {63'd0, s_pend},  64'd0);
        chk("R1 vs_pend in reset", {63'd0, vs_pend}, 64'd0);
        rst_n = 1'b1;
        exp_pend("R1 after reset");
        exp_rd("R1 s reset value", 12'h14D, 64'd0);
        exp_rd("R1 vs reset value", 12'h24D, '1);

        // R4 / R8: full write, flag falls, then crossing points
        csr_wr(12'h14D, 64'h0000_0001_0000_0000);
        exp_rd("R4 s full read", 12'h14D, 64'h0000_0001_0000_0000);
        exp_pend("R8 s cleared by larger compare");
        tm = 64'h0000_0001_0000_0000;
        exp_pend("R2 time equal to compare");
        tm = 64'h0000_0000_FFFF_FFFF;
        exp_pend("R2 time one below compare");

        // R2: one clock of latency
        @(negedge clk);
        tm = 64'h0000_0001_0000_0005;
        #1 chk("R2 flag not yet updated", {63'd0, s_pend}, 64'd0);
        @(negedge clk);
        chk("R2 flag updated after one edge", {63'd0, s_pend}, 64'd1);

        // R9: unsigned split at bit 63
        csr_wr(12'h14D, 64'h7FFF_FFFF_FFFF_FFFF);
        tm = 64'h8000_0000_0000_0000;
        exp_pend("R9 unsigned compare");

        // R3: VS time base
        csr_wr(12'h24D, 64'h100);
        exp_rd("R4 vs full read", 12'h24D, 64'h100);
        tm = 64'hF0; dl = 64'h10;
        exp_pend("R3 sum equal to vs compare");
        dl = 64'h0F;
        exp_pend("R3 sum one below vs compare");

        // R10: wrapped sum
        csr_wr(12'h24D, 64'h20);
        tm = 64'hFFFF_FFFF_FFFF_FFF8; dl = 64'h20;
        exp_pend("R10 wrapped sum below compare");
        dl = 64'h30;
        exp_pend("R10 wrapped sum above compare");

        // R6: upper addresses silent in 64-bit mode
        csr_wr(12'h15D, 64'hDEAD_BEEF_DEAD_BEEF);
        exp_rd("R6 s high reads zero", 12'h15D, 64'd0);
        exp_rd("R6 s unchanged", 12'h14D, m_s);
        csr_wr(12'h25D, 64'h1234);
        exp_rd("R6 vs high reads zero", 12'h25D, 64'd0);

        // R5: split access
        xlen64 = 1'b0;
        csr_wr(12'h14D, 64'hAAAA_AAAA_1234_5678);
        exp_rd("R5 s low read", 12'h14D, 64'h0000_0000_1234_5678);
        exp_rd("R5 s high kept", 12'h15D, 64'h0000_0000_7FFF_FFFF);
        csr_wr(12'h15D, 64'h5555_5555_0000_00C3);
        exp_rd("R5 s high read", 12'h15D, 64'h0000_0000_0000_00C3);
        exp_rd("R5 s low kept", 12'h14D, 64'h0000_0000_1234_5678);
        csr_wr(12'h25D, 64'h0000_0000_0000_0009);
        exp_rd("R5 vs low kept", 12'h24D, 64'h0000_0000_0000_0020);
        exp_rd("R5 vs high read", 12'h25D, 64'h0000_0000_0000_0009);
        xlen64 = 1'b1;
        exp_rd("R5 s full after halves", 12'h14D, 64'h0000_00C3_1234_5678);
        exp_rd("R5 vs full after halves", 12'h24D, 64'h0000_0009_0000_0020);
        exp_pend("R5 flags after split writes");

        // R7: unmapped address
        csr_wr(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        exp_rd("R7 unmapped reads zero", 12'h300, 64'd0);
        exp_rd("R7 s unchanged", 12'h14D, 64'h0000_00C3_1234_5678);
        exp_rd("R7 vs unchanged", 12'h24D, 64'h0000_0009_0000_0020);
        exp_pend("R7 flags unchanged");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule